// File: doc/BRIEF.md
# SPI Master Bit-Clock Generator

This block makes the serial bit clock for an SPI-style port. It runs entirely on the peripheral clock. A fixed prescaler divides that clock by 4 or by 32 and gives a one-cycle intermediate enable. A programmable half-period counter then holds each high and each low phase of the bit clock for N+1 of those intermediate ticks. The output rate is therefore the peripheral clock divided by the prescale factor and then by 2×(N+1). Alongside the bit clock it gives one-cycle leading-edge and trailing-edge strobes, which an external shifter uses to shift and sample data.

Configuration is written with a strobe. If a write changes any of the four clock or frame fields (frame setting, clock polarity, prescale select, division count), the block clears its counters, returns the bit clock to its new idle level, and sends a one-cycle soft-reset pulse to the rest of the serial module. In slave mode the block does not drive the clock. It synchronises the external bit clock, makes the same strobes from its edges, and raises a rate error when two external edges arrive fewer than 4 peripheral cycles apart.

Top module: `spi_bitclk_gen`

## Requirements
- R1: The intermediate tick comes every 4 peripheral cycles when the prescale select is 0 and every 32 peripheral cycles when it is 1.
- R2: In master mode with a transfer active, every high phase and every low phase of the bit clock lasts (N+1)×prescale peripheral cycles, where N is the 5-bit division count (0 to 31).
- R3: When a transfer starts (transfer enable first sampled high at peripheral edge k), the first bit-clock change happens at edge k+(N+1)×prescale.
- R4: While no transfer is active, the bit clock sits at the polarity bit's value (0 gives idle low, 1 gives idle high) and no strobe is emitted.
- R5: The leading strobe pulses for one cycle, in the same cycle that the bit clock leaves its idle level. The trailing strobe pulses for one cycle, in the same cycle that it returns to idle. The two strobes never fire together.
- R6: A configuration write that changes the frame, polarity, prescale or division field gives a soft-reset pulse in the cycle after the write. A write that repeats the held values gives no pulse.
- R7: A configuration-changing write puts the bit clock at the new idle level in the very next cycle and restarts the counters. If the transfer enable stays high, the first edge then comes (N+1)×prescale cycles after the edge that follows the write.
- R8: In slave mode the output enable is low, the bit clock output rests at idle, and the prescale and division fields have no effect. There is one leading strobe per external change away from idle and one trailing strobe per external change back to idle.
- R9: In slave mode the rate error pulses when two synchronised external edges are fewer than 4 peripheral cycles apart. It stays low at a spacing of 4 or more, and it never fires in master mode.
- R10: After reset all fields are 0, so a transfer started without any write gives a bit clock with a period of 8 peripheral cycles and an idle-low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_frame | input | 1 | Frame-setting bit (only compared, to detect a change) |
| cfg_cpol | input | 1 | Clock polarity, which is the idle level |
| cfg_pre_sel | input | 1 | Prescale select: 0 divides by 4, 1 divides by 32 |
| cfg_div | input | 5 | Half-period count N |
| master_en | input | 1 | 1 = master, 0 = slave |
| xfer_en | input | 1 | Transfer active (level) |
| ext_sck | input | 1 | External bit clock (slave mode) |
| sck_out | output | 1 | Generated bit clock |
| sck_oe | output | 1 | Bit-clock drive enable |
| lead_stb | output | 1 | Leading-edge strobe |
| trail_stb | output | 1 | Trailing-edge strobe |
| soft_rst | output | 1 | One-cycle soft-reset request |
| rate_err | output | 1 | External clock too fast (slave) |

## Verification
The hardest case to reach is a configuration change in the middle of a transfer. The write must land while the bit clock sits away from idle, with the transfer enable still high. The bench raises the enable, waits into the first high phase, and then flips the polarity. It checks the jump to the new idle level and the restarted first-edge timing. Rate-error boundaries are reached by driving the external clock with half-periods of 2, 3, 4, 5 and 8 cycles. This shows that an error appears exactly below a spacing of 4.

// File: rtl/spi_bclk_pkg.sv
// Shared types for the bit-clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_bclk_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE  = 2'd0,
        EDGE_LEAD  = 2'd1,
        EDGE_TRAIL = 2'd2
    } bclk_edge_e;
endpackage

// File: rtl/spi_bclk_cfg.sv
// Holds the clock/frame fields and flags any write that changes them.
// Assumes: wr is a single-cycle strobe in the clk domain.
module spi_bclk_cfg #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             frame_in,
    input  logic             cpol_in,
    input  logic             pre_in,
    input  logic [DIV_W-1:0] div_in,
    output logic             cpol_q,
    output logic             pre_q,
    output logic [DIV_W-1:0] div_q,
    output logic             chg,
    output logic             soft_rst
);
    logic frame_q;

    // detect a write whose value differs from the held fields
    assign chg = wr && ({frame_in, cpol_in, pre_in, div_in} != {frame_q, cpol_q, pre_q, div_q});

    // hold the fields; pulse soft reset one cycle after a change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q  <= 1'b0;
            cpol_q   <= 1'b0;
            pre_q    <= 1'b0;
            div_q    <= '0;
            soft_rst <= 1'b0;
        end else begin
            soft_rst <= chg;
            if (chg) begin
                frame_q <= frame_in;
                cpol_q  <= cpol_in;
                pre_q   <= pre_in;
                div_q   <= div_in;
            end
        end
    end
endmodule

// File: rtl/spi_bclk_master.sv
// Two-stage divider: prescale enable (/PRE_LO or /PRE_HI), then an
// (N+1)-tick half-period counter that toggles the bit clock.
// Assumes: clr is high for one cycle on a configuration change; idle_nxt
// already carries the polarity that will be held after that cycle.
module spi_bclk_master
    import spi_bclk_pkg::*;
#(
    parameter int DIV_W  = 5,
    parameter int PRE_LO = 4,
    parameter int PRE_HI = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run_req,
    input  logic             idle_nxt,
    input  logic             pre_sel,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output bclk_edge_e       edge_q
);
    localparam int PW = $clog2(PRE_HI);
    localparam logic [PW-1:0] LIM_LO = PW'(PRE_LO - 1);
    localparam logic [PW-1:0] LIM_HI = PW'(PRE_HI - 1);

    logic             run_q;
    logic [PW-1:0]    pre_cnt;
    logic [DIV_W-1:0] half_cnt;
    logic             tick;
    logic             flip;

    assign tick = run_q && (pre_cnt == (pre_sel ? LIM_HI : LIM_LO));
    assign flip = tick && (half_cnt == div);

    // register the run request; a config change drops it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_req && !clr;
    end

    // prescaler producing the intermediate tick
    always_ff @(posedge clk) begin
        if (!rst_n)                     pre_cnt <= '0;
        else if (clr || !run_q || tick) pre_cnt <= '0;
        else                            pre_cnt <= pre_cnt + 1'b1;
    end

    // half-period counter in intermediate ticks
    always_ff @(posedge clk) begin
        if (!rst_n)              half_cnt <= '0;
        else if (clr || !run_q)  half_cnt <= '0;
        else if (tick)           half_cnt <= flip ? '0 : half_cnt + 1'b1;
    end

    // bit clock: idle when stopped, toggles at the end of each half period
    always_ff @(posedge clk) begin
        if (!rst_n)             sck <= 1'b0;
        else if (clr || !run_q) sck <= idle_nxt;
        else if (flip)          sck <= ~sck;
    end

    // edge strobe aligned with the bit-clock change
    always_ff @(posedge clk) begin
        if (!rst_n)            edge_q <= EDGE_NONE;
        else if (clr || !flip) edge_q <= EDGE_NONE;
        else                   edge_q <= (sck == idle_nxt) ? EDGE_LEAD : EDGE_TRAIL;
    end
endmodule

// File: rtl/spi_bclk_slave.sv
// Follows an external bit clock: synchroniser, edge strobes, and a
// minimum-spacing check between successive edges.
// Assumes: ext_sck is asynchronous to clk; MIN_HALF >= 2.
module spi_bclk_slave
    import spi_bclk_pkg::*;
#(
    parameter int MIN_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       ext_sck,
    input  logic       cpol,
    output bclk_edge_e edge_q,
    output logic       fast_err
);
    localparam int CW = $clog2(MIN_HALF + 1);
    localparam logic [CW-1:0] GAP_SAT = CW'(MIN_HALF);

    logic [2:0]    sync_q;
    logic [CW-1:0] gap;
    logic          ext_edge;

    assign ext_edge = sync_q[1] ^ sync_q[2];

    // three-stage shift: two for metastability, one for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_sck};
    end

    // cycles since the last edge, saturating at MIN_HALF
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       gap <= GAP_SAT;
        else if (ext_edge)       gap <= CW'(1);
        else if (gap != GAP_SAT) gap <= gap + 1'b1;
    end

    // strobes and the too-fast flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            edge_q   <= EDGE_NONE;
            fast_err <= 1'b0;
        end else begin
            fast_err <= ext_edge && (gap < GAP_SAT);
            if (!ext_edge)              edge_q <= EDGE_NONE;
            else if (sync_q[1] != cpol) edge_q <= EDGE_LEAD;
            else                        edge_q <= EDGE_TRAIL;
        end
    end
endmodule

// File: rtl/spi_bitclk_gen.sv
// Top: configuration hold, master divider and slave follower, with
// outputs selected by the mode bit.
// Assumes: master_en changes only while no transfer is active.
module spi_bitclk_gen
    import spi_bclk_pkg::*;
#(
    parameter int DIV_W    = 5,
    parameter int PRE_LO   = 4,
    parameter int PRE_HI   = 32,
    parameter int MIN_HALF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_frame,
    input  logic             cfg_cpol,
    input  logic             cfg_pre_sel,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             master_en,
    input  logic             xfer_en,
    input  logic             ext_sck,
    output logic             sck_out,
    output logic             sck_oe,
    output logic             lead_stb,
    output logic             trail_stb,
    output logic             soft_rst,
    output logic             rate_err
);
    logic             cpol_q;
    logic             pre_q;
    logic [DIV_W-1:0] div_q;
    logic             chg;
    logic             idle_nxt;
    logic             m_sck;
    bclk_edge_e       m_edge;
    bclk_edge_e       s_edge;
    bclk_edge_e       sel_edge;
    logic             s_err;

    spi_bclk_cfg #(.DIV_W(DIV_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
        .frame_in(cfg_frame), .cpol_in(cfg_cpol), .pre_in(cfg_pre_sel), .div_in(cfg_div),
        .cpol_q(cpol_q), .pre_q(pre_q), .div_q(div_q),
        .chg(chg), .soft_rst(soft_rst)
    );

    assign idle_nxt = chg ? cfg_cpol : cpol_q;

    spi_bclk_master #(.DIV_W(DIV_W), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) mst_i (
        .clk(clk), .rst_n(rst_n), .clr(chg),
        .run_req(master_en && xfer_en), .idle_nxt(idle_nxt),
        .pre_sel(pre_q), .div(div_q),
        .sck(m_sck), .edge_q(m_edge)
    );

    spi_bclk_slave #(.MIN_HALF(MIN_HALF)) slv_i (
        .clk(clk), .rst_n(rst_n), .clr(chg),
        .ext_sck(ext_sck), .cpol(cpol_q),
        .edge_q(s_edge), .fast_err(s_err)
    );

    // mode select for the outputs
    always_comb begin
        sel_edge  = master_en ? m_edge : s_edge;
        sck_oe    = master_en;
        sck_out   = master_en ? m_sck : cpol_q;
        lead_stb  = (sel_edge == EDGE_LEAD);
        trail_stb = (sel_edge == EDGE_TRAIL);
        rate_err  = s_err && !master_en;
    end
endmodule

// File: rtl/spi_bitclk_gen_chk.sv
// Property checker for spi_bitclk_gen, attached by bind below.
// Assumes: synchronous active-low reset.
module spi_bitclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic master_en,
    input logic xfer_en,
    input logic sck_out,
    input logic lead_stb,
    input logic trail_stb,
    input logic soft_rst,
    input logic rate_err,
    input logic cpol_q
);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    // R5
    lead_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && lead_stb) |-> (sck_out != cpol_q));

    // R5
    trail_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && trail_stb) |-> (sck_out == cpol_q));

    // R6
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(cfg_wr));

    // R7
    rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (sck_out == cpol_q));

    // R4
    idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && $past(master_en) && !$past(xfer_en) && !$past(xfer_en, 2))
        |-> (sck_out == cpol_q && !lead_stb && !trail_stb));

    // R9
    err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_err |-> !$past(master_en));
endmodule

bind spi_bitclk_gen spi_bitclk_gen_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .master_en(master_en),
    .xfer_en(xfer_en), .sck_out(sck_out), .lead_stb(lead_stb),
    .trail_stb(trail_stb), .soft_rst(soft_rst), .rate_err(rate_err),
    .cpol_q(cpol_q)
);

// File: tb/spi_bitclk_gen_tb.sv
// Self-checking bench: sweeps prescale x division count in master mode,
// mid-transfer change, and slave edge spacing.
module spi_bitclk_gen_tb_top;
    localparam int CLK_NS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_frame = 1'b0;
    logic       cfg_cpol = 1'b0;
    logic       cfg_pre_sel = 1'b0;
    logic [4:0] cfg_div = '0;
    logic       master_en = 1'b1;
    logic       xfer_en = 1'b0;
    logic       ext_sck = 1'b0;
    logic       sck_out, sck_oe, lead_stb, trail_stb, soft_rst, rate_err;

    int n_chk = 0;
    int n_bad = 0;
    int lead_cnt = 0, trail_cnt = 0, err_cnt = 0;
    logic m_frame = 0, m_cpol = 0, m_pre = 0;
    logic [4:0] m_div = '0;

    spi_bitclk_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_frame(cfg_frame),
        .cfg_cpol(cfg_cpol), .cfg_pre_sel(cfg_pre_sel), .cfg_div(cfg_div),
        .master_en(master_en), .xfer_en(xfer_en), .ext_sck(ext_sck),
        .sck_out(sck_out), .sck_oe(sck_oe), .lead_stb(lead_stb),
        .trail_stb(trail_stb), .soft_rst(soft_rst), .rate_err(rate_err)
    );

    always #(CLK_NS/2) clk = ~clk;

    // strobe and error tallies, sampled mid-cycle
    always @(negedge clk) begin
        lead_cnt  <= lead_cnt + int'(lead_stb);
        trail_cnt <= trail_cnt + int'(trail_stb);
        err_cnt   <= err_cnt + int'(rate_err);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // write configuration while idle; expect a pulse only on a change
    task automatic write_cfg(input logic f, input logic c, input logic p, input logic [4:0] d);
        bit changed;
        changed = ({f, c, p, d} != {m_frame, m_cpol, m_pre, m_div});
        @(negedge clk);
        cfg_frame = f; cfg_cpol = c; cfg_pre_sel = p; cfg_div = d; cfg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(soft_rst == changed, "R6 soft reset on change", int'(soft_rst), int'(changed));
        m_frame = f; m_cpol = c; m_pre = p; m_div = d;
        if (master_en)
            chk(sck_out == c, "R4 idle level after write", int'(sck_out), int'(c));
    endtask

    // count from the start edge (first posedge = 1); check four edges
    task automatic measure(input int n, input int pre, input string tag);
        int half, toggles, bad_stb, exp_c;
        logic prev;
        half = (n + 1) * pre;
        prev = sck_out;
        toggles = 0;
        bad_stb = 0;
        for (int cyc = 1; cyc <= 4 * half + 8; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            if (sck_out !== prev) begin
                toggles++;
                exp_c = half * toggles + 1;
                chk(cyc == exp_c, (toggles == 1) ? {tag, " R3 first edge"} : {tag, " R2/R1 half period"},
                    cyc, exp_c);
                if (sck_out != m_cpol)
                    chk(lead_stb && !trail_stb, {tag, " R5 lead strobe"}, int'(lead_stb), 1);
                else
                    chk(trail_stb && !lead_stb, {tag, " R5 trail strobe"}, int'(trail_stb), 1);
                prev = sck_out;
                if (toggles == 4) break;
            end else if (lead_stb || trail_stb) begin
                bad_stb++;
            end
        end
        chk(toggles == 4, {tag, " R2 edge count"}, toggles, 4);
        chk(bad_stb == 0, {tag, " R5 stray strobe"}, bad_stb, 0);
    endtask

    task automatic stop_and_idle(input string tag);
        @(negedge clk);
        xfer_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(sck_out == m_cpol, {tag, " R4 idle after stop"}, int'(sck_out), int'(m_cpol));
        chk(!lead_stb && !trail_stb, {tag, " R4 no strobe idle"}, int'(lead_stb | trail_stb), 0);
    endtask

    task automatic run_case(input int pre_sel, input int n, input logic c);
        write_cfg(1'b0, c, pre_sel[0], 5'(n));
        @(negedge clk);
        xfer_en = 1'b1;
        measure(n, pre_sel ? 32 : 4, $sformatf("pre=%0d n=%0d", pre_sel, n));
        stop_and_idle("sweep");
    endtask

    // slave: toggle ext_sck every h cycles, then tally strobes and errors
    task automatic slave_run(input int h, input int toggles, input bit want_err, input string tag);
        int l0, t0, e0;
        @(negedge clk);
        l0 = lead_cnt; t0 = trail_cnt; e0 = err_cnt;
        for (int i = 0; i < toggles; i++) begin
            repeat (h) @(negedge clk);
            ext_sck = ~ext_sck;
        end
        repeat (8) @(negedge clk);
        chk(lead_cnt - l0 == toggles / 2, {tag, " R8 lead count"}, lead_cnt - l0, toggles / 2);
        chk(trail_cnt - t0 == toggles / 2, {tag, " R8 trail count"}, trail_cnt - t0, toggles / 2);
        chk(!sck_oe && sck_out == m_cpol, {tag, " R8 no drive"}, int'(sck_oe), 0);
        if (want_err) chk(err_cnt - e0 > 0, {tag, " R9 error seen"}, err_cnt - e0, 1);
        else          chk(err_cnt - e0 == 0, {tag, " R9 no error"}, err_cnt - e0, 0);
    endtask

    initial begin : watchdog
        #(CLK_NS * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(sck_out == 1'b0 && sck_oe == 1'b1, "R10 reset clock low", int'(sck_out), 0);
        chk(!soft_rst && !lead_stb && !trail_stb && !rate_err, "R10 reset outputs quiet",
            int'(soft_rst | lead_stb | trail_stb | rate_err), 0);
        // R10 default rate: half 4 cycles, period 8
        xfer_en = 1'b1;
        measure(0, 4, "R10 default");
        stop_and_idle("R10");

        // R1 R2 R3 sweep
        for (int n = 0; n < 32; n++) run_case(0, n, logic'(n % 2));
        for (int n = 0; n < 32; n += 3) run_case(1, n, logic'((n + 1) % 2));
        run_case(1, 31, 1'b0);

        // R6 identical write: no pulse; frame-only change: pulse
        write_cfg(m_frame, m_cpol, m_pre, m_div);
        write_cfg(~m_frame, m_cpol, m_pre, m_div);

        // R7 change mid transfer while clock is away from idle
        write_cfg(m_frame, 1'b0, 1'b0, 5'd2);
        @(negedge clk);
        xfer_en = 1'b1;
        repeat (16) @(negedge clk);
        chk(sck_out == 1'b1, "R7 precondition clock high", int'(sck_out), 1);
        cfg_cpol = 1'b1; cfg_frame = m_frame; cfg_pre_sel = 1'b0; cfg_div = 5'd2; cfg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        m_cpol = 1'b1;
        chk(soft_rst == 1'b1, "R7 soft reset pulse", int'(soft_rst), 1);
        chk(sck_out == 1'b1 && !lead_stb && !trail_stb, "R7 idle at new polarity", int'(sck_out), 1);
        measure(2, 4, "R7 restart");
        stop_and_idle("R7");

        // R8 R9 slave mode
        write_cfg(m_frame, 1'b0, 1'b0, 5'd0);
        @(negedge clk);
        master_en = 1'b0;
        xfer_en = 1'b1;
        slave_run(8, 8, 1'b0, "slave h8");
        write_cfg(m_frame, 1'b0, 1'b1, 5'd31);
        slave_run(5, 8, 1'b0, "slave h5 div31");
        slave_run(4, 10, 1'b0, "slave h4");
        slave_run(3, 10, 1'b1, "slave h3");
        slave_run(2, 10, 1'b1, "slave h2");
        xfer_en = 1'b0;
        @(negedge clk);
        master_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(sck_oe == 1'b1 && !rate_err, "R9 master no error", int'(rate_err), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule